// File: doc/BRIEF.md
# Masked Content-Addressable Memory

A small associative store in which every entry holds a searchable key, a returned data word and a valid flag. A search offers one key. Each entry has its own comparator, and all of them test that key against their stored keys in the same cycle. No entry is scanned after another. A global mask register picks the bit subfield of the key that takes part in the compare, so any subfield can serve as the search key. Bits that the mask excludes always count as equal.

When several entries match, the one with the lowest index supplies the result and a separate flag reports the multiple match. The hit flag, index and data are registered and appear one cycle after the search strobe. Used as a cache tag store, the incoming tag is the key and a hit returns the associated data word. One write port loads an entry or clears its valid flag.

Top module: `mcam_top`

## Requirements
- R1: After reset every entry is invalid, the mask register is all ones, and res_vld_o, hit_o, multi_o, hit_idx_o and hit_data_o are all zero.
- R2: A clock edge with wr_en_i high and wr_op_i=1 stores wr_key_i and wr_data_i at index wr_idx_i and marks the entry valid. With wr_op_i=0 the same edge marks that entry invalid.
- R3: A search compares srch_key_i against every entry at once. An entry matches only if it is valid and its key equals srch_key_i on every bit the mask enables.
- R4: A mask bit of 1 puts that key bit into the compare. A mask bit of 0 makes that bit count as equal. mask_we_i high loads mask_i at the clock edge.
- R5: When two or more entries match, hit_idx_o and hit_data_o come from the lowest matching index and multi_o is 1. With exactly one match, multi_o is 0.
- R6: res_vld_o is 1 in the cycle after a cycle with srch_i high and 0 otherwise. hit_o, multi_o, hit_idx_o and hit_data_o then show the result of that search.
- R7: A search with no match gives hit_o=0, multi_o=0, hit_idx_o=0 and hit_data_o=0.
- R8: In a cycle without srch_i, hit_o, multi_o, hit_idx_o and hit_data_o keep their values.
- R9: A write in the same cycle as a search does not affect that search. The search sees the entry contents from before the write, and a search in the next cycle sees the new contents.
- R10: A mask load in the same cycle as a search does not affect that search, which uses the old mask. The new mask applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_op_i | input | 1 | 1 = load entry, 0 = invalidate entry |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_key_i | input | KEY_W | Key to store |
| wr_data_i | input | DATA_W | Data to store |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | KEY_W | New mask value, 1 = bit compared |
| srch_i | input | 1 | Search strobe |
| srch_key_i | input | KEY_W | Key to search for |
| res_vld_o | output | 1 | Result of the previous cycle's search is present |
| hit_o | output | 1 | At least one entry matched |
| multi_o | output | 1 | Two or more entries matched |
| hit_idx_o | output | IDX_W | Lowest matching index |
| hit_data_o | output | DATA_W | Data of the lowest matching entry |

## Verification
On every cycle the assertions check the following:
- The one-cycle delay from the search strobe to res_vld_o.
- That the result registers hold between searches.
- That a multiple match implies a hit.
- That a miss returns a zero index and zero data.
- That the internal lowest-index grant never selects more than one entry.

Only the bench scenarios can show the match decision itself. The bench compares each result with a reference model for the following cases:
- A mask that selects a subfield.
- A fully open mask.
- Duplicated keys.
- Invalidated entries.
- A write or a mask load in the same cycle as a search, which must not disturb that search.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
  typedef enum logic {
    WR_DROP = 1'b0,
    WR_LOAD = 1'b1
  } wr_op_e;

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/mcam_store.sv
module mcam_store
  import mcam_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  wr_op_e                         wr_op_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [KEY_W-1:0]               wr_key_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [DEPTH-1:0][KEY_W-1:0]    key_o,
  output logic [DEPTH-1:0][DATA_W-1:0]   data_o,
  output logic [DEPTH-1:0]               vld_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_o[g]  <= '0;
        data_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (sel) begin
        vld_o[g] <= (wr_op_i == WR_LOAD);
        if (wr_op_i == WR_LOAD) begin
          key_o[g]  <= wr_key_i;
          data_o[g] <= wr_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/mcam_match.sv
module mcam_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned KEY_W = 16
) (
  input  logic [DEPTH-1:0][KEY_W-1:0] key_i,
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [KEY_W-1:0]            srch_key_i,
  input  logic [KEY_W-1:0]            mask_i,
  output logic [DEPTH-1:0]            match_o
);
  // one comparator per entry; masked-off bits never differ
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [KEY_W-1:0] diff;
    assign diff       = (key_i[g] ^ srch_key_i) & mask_i;
    assign match_o[g] = vld_i[g] && (diff == '0);
  end
endmodule

// File: rtl/mcam_prio.sv
module mcam_prio
  import mcam_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic [DEPTH-1:0]             req_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
  output logic [DEPTH-1:0]             gnt_o,
  output logic                         any_o,
  output logic                         multi_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [DATA_W-1:0]            data_o
);
  // isolate lowest set bit
  assign gnt_o   = req_i & (~req_i + DEPTH'(1));
  assign any_o   = |req_i;
  assign multi_o = |(req_i & ~gnt_o);

  always_comb begin
    idx_o  = '0;
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt_o[i]) begin
        idx_o  = idx_o | IDX_W'(i);
        data_o = data_o | data_i[i];
      end
    end
  end
endmodule

// File: rtl/mcam_top.sv
module mcam_top
  import mcam_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_op_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mask_we_i,
  input  logic [KEY_W-1:0]  mask_i,
  input  logic              srch_i,
  input  logic [KEY_W-1:0]  srch_key_i,
  output logic              res_vld_o,
  output logic              hit_o,
  output logic              multi_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o
);
  logic [DEPTH-1:0][KEY_W-1:0]  ent_key;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0]             match;
  logic [DEPTH-1:0]             grant;
  logic                         any_hit;
  logic                         many_hit;
  logic [IDX_W-1:0]             sel_idx;
  logic [DATA_W-1:0]            sel_data;
  logic [KEY_W-1:0]             mask_q;

  mcam_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_op_i   (wr_op_e'(wr_op_i)),
    .wr_idx_i  (wr_idx_i),
    .wr_key_i  (wr_key_i),
    .wr_data_i (wr_data_i),
    .key_o     (ent_key),
    .data_o    (ent_data),
    .vld_o     (ent_vld)
  );

  mcam_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_match (
    .key_i      (ent_key),
    .vld_i      (ent_vld),
    .srch_key_i (srch_key_i),
    .mask_i     (mask_q),
    .match_o    (match)
  );

  mcam_prio #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_prio (
    .req_i   (match),
    .data_i  (ent_data),
    .gnt_o   (grant),
    .any_o   (any_hit),
    .multi_o (many_hit),
    .idx_o   (sel_idx),
    .data_o  (sel_data)
  );

  // mask resets to all ones: full-key compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      hit_o      <= 1'b0;
      multi_o    <= 1'b0;
      hit_idx_o  <= '0;
      hit_data_o <= '0;
    end else begin
      res_vld_o <= srch_i;
      if (srch_i) begin
        hit_o      <= any_hit;
        multi_o    <= many_hit;
        hit_idx_o  <= sel_idx;
        hit_data_o <= sel_data;
      end
    end
  end
endmodule

// File: rtl/mcam_chk.sv
module mcam_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srch_i,
  input logic              res_vld_o,
  input logic              hit_o,
  input logic              multi_o,
  input logic [IDX_W-1:0]  hit_idx_o,
  input logic [DATA_W-1:0] hit_data_o,
  input logic [DEPTH-1:0]  grant
);
  // R6
  res_follows_srch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_i |=> res_vld_o);
  // R6
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_i |=> !res_vld_o);
  // R5
  multi_implies_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);
  // R5
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  // R7
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0 && hit_data_o == '0 && !multi_o));
  // R8
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_i |=> ($stable(hit_o) && $stable(multi_o) && $stable(hit_idx_o)
                 && $stable(hit_data_o)));
endmodule

bind mcam_top mcam_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srch_i     (srch_i),
  .res_vld_o  (res_vld_o),
  .hit_o      (hit_o),
  .multi_o    (multi_o),
  .hit_idx_o  (hit_idx_o),
  .hit_data_o (hit_data_o),
  .grant      (grant)
);

// File: tb/tb_mcam_top.sv
module tb_mcam_top;
  localparam int DEPTH = 8, KEY_W = 16, DATA_W = 16, IDX_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wr_op_i = 0, mask_we_i = 0, srch_i = 0;
  logic [IDX_W-1:0]  wr_idx_i = '0;
  logic [KEY_W-1:0]  wr_key_i = '0, mask_i = '0, srch_key_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic res_vld_o, hit_o, multi_o;
  logic [IDX_W-1:0]  hit_idx_o;
  logic [DATA_W-1:0] hit_data_o;

  mcam_top #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [KEY_W-1:0]  m_key  [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];
  logic              m_vld  [DEPTH];
  logic [KEY_W-1:0]  m_mask;
  logic [DATA_W+IDX_W+2:0] last_exp;

  // {res_vld, hit, multi, idx, data}
  function automatic logic [DATA_W+IDX_W+2:0] model(input logic [KEY_W-1:0] k);
    logic h = 0, mu = 0;
    logic [IDX_W-1:0] ix = '0;
    logic [DATA_W-1:0] d = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && (((m_key[i] ^ k) & m_mask) == '0)) begin
        if (h) mu = 1;
        else begin h = 1; ix = IDX_W'(i); d = m_data[i]; end
      end
    return {1'b1, h, mu, ix, d};
  endfunction

  task automatic check(input string req, input logic [DATA_W+IDX_W+2:0] exp);
    logic [DATA_W+IDX_W+2:0] got = {res_vld_o, hit_o, multi_o, hit_idx_o, hit_data_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic op, input logic [KEY_W-1:0] k,
                    input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_op_i = op; wr_idx_i = IDX_W'(idx); wr_key_i = k; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
    m_vld[idx] = op;
    if (op) begin m_key[idx] = k; m_data[idx] = d; end
  endtask

  task automatic set_mask(input logic [KEY_W-1:0] m);
    @(negedge clk_i);
    mask_we_i = 1; mask_i = m;
    @(negedge clk_i);
    mask_we_i = 0;
    m_mask = m;
  endtask

  task automatic search(input string req, input logic [KEY_W-1:0] k);
    @(negedge clk_i);
    srch_i = 1; srch_key_i = k;
    last_exp = model(k);
    @(negedge clk_i);
    srch_i = 0;
    check(req, last_exp);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", '0);
    search("R1 empty store misses", 16'h0000);
    wr(0, 1, 16'h1234, 16'hBEEF);
    search("R1 mask all ones compares every bit", 16'h1235);
    search("R3 exact key hits", 16'h1234);
  endtask

  task automatic t_load();
    for (int i = 0; i < 6; i++) wr(i, 1, 16'h1000 + 16'(i) * 16'h0111, 16'hA000 + 16'(i));
    for (int i = 0; i < 6; i++) search("R2 R3 loaded entry hits", 16'h1000 + 16'(i) * 16'h0111);
    search("R7 absent key misses", 16'h5A5A);
  endtask

  task automatic t_invalidate();
    wr(3, 0, 16'h0, 16'h0);
    search("R2 invalidated entry never matches", 16'h1333);
  endtask

  task automatic t_mask();
    set_mask(16'h00FF);
    search("R4 low-byte subfield search", 16'hEE44);
    set_mask(16'hFF00);
    search("R4 high-byte subfield search", 16'h15C3);
    set_mask(16'hFFFF);
  endtask

  task automatic t_multi();
    set_mask(16'h0000);
    search("R5 open mask: lowest valid wins, multi set", 16'hFFFF);
    set_mask(16'hFFFF);
    wr(6, 1, 16'h1222, 16'hC006);
    search("R5 duplicate key: lowest index wins", 16'h1222);
    wr(2, 0, 16'h0, 16'h0);
    search("R5 single match after invalidate", 16'h1222);
  endtask

  task automatic t_hold();
    logic [DATA_W+IDX_W+2:0] held;
    search("R6 search result", 16'h1111);
    held = {1'b0, last_exp[DATA_W+IDX_W+1:0]};
    repeat (3) @(negedge clk_i);
    check("R8 outputs hold without search", held);
  endtask

  task automatic t_wr_collide();
    logic [DATA_W+IDX_W+2:0] e;
    @(negedge clk_i);
    srch_i = 1; srch_key_i = 16'h7777;
    wr_en_i = 1; wr_op_i = 1; wr_idx_i = 3'd1; wr_key_i = 16'h7777; wr_data_i = 16'hD001;
    e = model(16'h7777);
    @(negedge clk_i);
    srch_i = 0; wr_en_i = 0;
    m_vld[1] = 1; m_key[1] = 16'h7777; m_data[1] = 16'hD001;
    check("R9 same-cycle write invisible to search", e);
    search("R9 write visible next cycle", 16'h7777);
  endtask

  task automatic t_mask_collide();
    logic [DATA_W+IDX_W+2:0] e;
    @(negedge clk_i);
    srch_i = 1; srch_key_i = 16'h14AB;
    mask_we_i = 1; mask_i = 16'hFF00;
    e = model(16'h14AB);
    @(negedge clk_i);
    srch_i = 0; mask_we_i = 0;
    m_mask = 16'hFF00;
    check("R10 same-cycle mask load invisible to search", e);
    search("R10 new mask used next cycle", 16'h14AB);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_key[i] = '0; m_data[i] = '0; m_vld[i] = 0; end
    m_mask = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_invalidate();
    t_mask();
    t_multi();
    t_hold();
    t_wr_collide();
    t_mask_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule